// File: doc/BRIEF.md
# Gap-Modulated Tag Write Sequencer

This block writes a data word into a low-frequency tag by switching the reader carrier on and off. It opens with a long field-off interval. Each bit then goes out as a field-on pulse whose length encodes the bit value, and a fixed field-off gap follows every bit. At the end the carrier is switched back on and held for a settling time, so that the tag can recover before it is read. The output `field_en` drives the enable of the 125 kHz carrier: 1 means the field is on.

All durations are parameters counted in microsecond ticks, which arrive on `us_tick` as one-clock strobes. The default values lengthen the gaps and shorten the pulses relative to the nominal timing, because the antenna's field takes time to decay. Defaults: start gap 400, write gap 160, data-0 pulse 144, data-1 pulse 400, settle 300.

Top module: `gapwrite_seq`

## Requirements
- R1: While reset is active, and after it is released with no start, `field_en`=1, `busy`=0 and `done`=0.
- R2: A `start` pulse sampled while idle sets `busy`=1 and `field_en`=0 at the next clock edge. The field then stays off for START_GAP_US ticks.
- R3: A data bit of value 0 is sent as `field_en`=1 for ZERO_US ticks.
- R4: A data bit of value 1 is sent as `field_en`=1 for ONE_US ticks.
- R5: Every bit pulse is followed by `field_en`=0 for WGAP_US ticks, including the pulse of the last bit.
- R6: Bits are taken from `data` starting at bit DATA_W-1 and moving down, so the first `nbits` bits from the top of the word are sent.
- R7: When `nbits`=0, the start gap is followed directly by the settle phase. A value of `nbits` above DATA_W is treated as DATA_W.
- R8: After the last gap, `field_en`=1 for SETTLE_US ticks with `busy` still 1. Then `busy` falls and `done` is 1 for exactly one clock, at the same edge.
- R9: A `start` pulse while `busy`=1 has no effect on the sequence.
- R10: A phase advances only on clocks where `us_tick`=1. The clock that accepts `start` does not count a tick.
- R11: A `start` sampled in the clock where `done` is 1 begins a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-clock strobe once per microsecond |
| start | input | 1 | Begin a write sequence (accepted only when idle) |
| data | input | DATA_W | Bits to send, top bit first |
| nbits | input | CNT_W | Number of bits to send (0..DATA_W, larger values are clamped) |
| field_en | output | 1 | Carrier enable, 1 means field on |
| busy | output | 1 | High from start until the settle phase ends |
| done | output | 1 | One-clock pulse when the sequence completes |

## Verification
Two events can fall in the same cycle: the tick that ends the settle phase and a new `start`. A start that arrives while the last settle tick is still pending must be dropped. A start sampled in the cycle where `done` is high must be taken. The bench pulses `start` repeatedly through a running sequence, including near its end, and also places `start` exactly in the `done` cycle. A behavioural model built from a list of segments predicts every output on every clock, which decides both cases.

// File: rtl/gw_pkg.sv
package gw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SGAP,
    PH_MARK,
    PH_WGAP,
    PH_SETTLE
  } phase_t;

  // Field-on width for one data bit.
  function automatic int mark_ticks(logic b, int zero_t, int one_t);
    return b ? one_t : zero_t;
  endfunction

  // Bit count limited to the word width.
  function automatic int clamp_count(int n, int lim);
    return (n > lim) ? lim : n;
  endfunction

endpackage

// File: rtl/gw_ustimer.sv
module gw_ustimer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  logic [TMR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expire = tick && (cnt == TMR_W'(1));
endmodule

// File: rtl/gw_bitq.sv
module gw_bitq #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic [CNT_W-1:0]  count,
  input  logic              advance,
  output logic              head_bit,
  output logic [CNT_W-1:0]  left
);
  logic [DATA_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr   <= '0;
      left <= '0;
    end else if (load) begin
      sr   <= data;
      left <= count;
    end else if (advance && left != '0) begin
      sr   <= sr << 1;
      left <= left - 1'b1;
    end
  end

  assign head_bit = sr[DATA_W-1];
endmodule

// File: rtl/gapwrite_seq.sv
module gapwrite_seq #(
  parameter int DATA_W       = 64,
  parameter int CNT_W        = $clog2(DATA_W + 1),
  parameter int TMR_W        = 16,
  parameter int START_GAP_US = 400,
  parameter int WGAP_US      = 160,
  parameter int ZERO_US      = 144,
  parameter int ONE_US       = 400,
  parameter int SETTLE_US    = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  input  logic [CNT_W-1:0]  nbits,
  output logic              field_en,
  output logic              busy,
  output logic              done
);
  import gw_pkg::*;

  phase_t             phase, nxt_phase;
  logic               field_q, nxt_field, done_q, nxt_done;
  logic               tmr_load, tmr_expire, q_load, q_adv;
  logic [TMR_W-1:0]   tmr_val;
  logic               head_bit;
  logic [CNT_W-1:0]   bits_left;
  logic [CNT_W-1:0]   bits_clamped;
  logic               phase_done;

  assign bits_clamped = CNT_W'(clamp_count(int'(nbits), DATA_W));
  assign phase_done   = (phase != PH_IDLE) && tmr_expire;

  gw_ustimer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .tick(us_tick), .expire(tmr_expire)
  );

  gw_bitq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_bits (
    .clk(clk), .rst_n(rst_n), .load(q_load), .data(data),
    .count(bits_clamped), .advance(q_adv), .head_bit(head_bit),
    .left(bits_left)
  );

  always_comb begin
    nxt_phase = phase;
    nxt_field = field_q;
    nxt_done  = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    q_load    = 1'b0;
    q_adv     = 1'b0;
    unique case (phase)
      PH_IDLE: if (start) begin
        nxt_phase = PH_SGAP;
        nxt_field = 1'b0;
        tmr_load  = 1'b1;
        tmr_val   = TMR_W'(START_GAP_US);
        q_load    = 1'b1;
      end
      PH_SGAP, PH_WGAP: if (phase_done) begin
        nxt_field = 1'b1;
        tmr_load  = 1'b1;
        if (bits_left != '0) begin
          nxt_phase = PH_MARK;
          tmr_val   = TMR_W'(mark_ticks(head_bit, ZERO_US, ONE_US));
        end else begin
          nxt_phase = PH_SETTLE;
          tmr_val   = TMR_W'(SETTLE_US);
        end
      end
      PH_MARK: if (phase_done) begin
        nxt_phase = PH_WGAP;
        nxt_field = 1'b0;
        tmr_load  = 1'b1;
        tmr_val   = TMR_W'(WGAP_US);
        q_adv     = 1'b1;
      end
      PH_SETTLE: if (phase_done) begin
        nxt_phase = PH_IDLE;
        nxt_done  = 1'b1;
      end
      default: nxt_phase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      field_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      phase   <= nxt_phase;
      field_q <= nxt_field;
      done_q  <= nxt_done;
    end
  end

  assign field_en = field_q;
  assign busy     = (phase != PH_IDLE);
  assign done     = done_q;
endmodule

// File: rtl/gw_chk.sv
module gw_chk #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             us_tick,
  input logic             start,
  input logic             field_en,
  input logic             busy,
  input logic             done,
  input logic             phase_done,
  input logic [CNT_W-1:0] bits_left
);
  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && field_en));

  a_r2_start_enters: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !field_en));

  a_r10_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !us_tick) |=> (busy && $stable(field_en)));

  a_r10_end_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done |-> us_tick);

  a_r9_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !phase_done) |=> busy);

  a_r7_bits_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bits_left) <= DATA_W);
endmodule

bind gapwrite_seq gw_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start(start),
  .field_en(field_en), .busy(busy), .done(done),
  .phase_done(phase_done), .bits_left(bits_left)
);

// File: tb/sim_gapwrite_seq.sv
module sim_gapwrite_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 64;
  localparam int CW  = 7;
  localparam int T_SG = 5, T_WG = 3, T_Z = 2, T_O = 6, T_ST = 4;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0, start = 1'b0;
  logic [DW-1:0] data = '0;
  logic [CW-1:0] nbits = '0;
  logic field_en, busy, done;

  int checks = 0, fails = 0, cyc = 0, tick_div = 1, tick_ph = 0;
  string tag = "R1";
  bit e_field = 1'b1, e_busy = 1'b0, e_done = 1'b0;
  int lvl_q[$];
  int dur_q[$];

  gapwrite_seq #(.DATA_W(DW), .CNT_W(CW), .START_GAP_US(T_SG), .WGAP_US(T_WG),
    .ZERO_US(T_Z), .ONE_US(T_O), .SETTLE_US(T_ST)) u0 (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start(start), .data(data),
    .nbits(nbits), .field_en(field_en), .busy(busy), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: a list of (level, duration) segments per sequence.
  always @(posedge clk) begin
    if (!rst_n) begin
      e_field = 1'b1; e_busy = 1'b0; e_done = 1'b0;
      lvl_q.delete(); dur_q.delete();
    end else begin
      e_done = 1'b0;
      if (!e_busy) begin
        if (start) begin
          int n;
          n = (int'(nbits) > DW) ? DW : int'(nbits);
          lvl_q.push_back(0); dur_q.push_back(T_SG);
          for (int i = 0; i < n; i++) begin
            lvl_q.push_back(1); dur_q.push_back(data[DW-1-i] ? T_O : T_Z);
            lvl_q.push_back(0); dur_q.push_back(T_WG);
          end
          lvl_q.push_back(1); dur_q.push_back(T_ST);
          e_busy = 1'b1; e_field = lvl_q[0][0];
        end
      end else if (us_tick) begin
        dur_q[0] = dur_q[0] - 1;
        if (dur_q[0] == 0) begin
          void'(lvl_q.pop_front()); void'(dur_q.pop_front());
          if (lvl_q.size() == 0) begin
            e_busy = 1'b0; e_done = 1'b1; e_field = 1'b1;
          end else e_field = lvl_q[0][0];
        end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Compare on every clock, away from the active edge; drive tick here too.
  always @(negedge clk) begin
    cyc++;
    checks++;
    if (field_en !== e_field || busy !== e_busy || done !== e_done) begin
      fails++;
      $display("FAIL %s cycle %0d: field_en/busy/done actual %b%b%b expected %b%b%b",
               tag, cyc, field_en, busy, done, e_field, e_busy, e_done);
    end
    tick_ph = (tick_ph + 1) % tick_div;
    us_tick <= (tick_ph == 0);
    if (cyc > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d, actual running expected finished", cyc);
      finish_run();
    end
  end

  task automatic pulse_start(input logic [DW-1:0] d, input int n);
    @(negedge clk);
    data <= d; nbits <= CW'(n); start <= 1'b1;
    @(negedge clk);
    start <= 1'b0;
  endtask

  task automatic wait_done();
    while (done !== 1'b1) @(negedge clk);
  endtask

  task automatic run_seq(input string t, input logic [DW-1:0] d, input int n, input int div);
    tag = t; tick_div = div;
    pulse_start(d, n);
    wait_done();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    checks++;
    if (field_en !== 1'b1 || busy !== 1'b0 || done !== 1'b0) begin
      fails++;
      $display("FAIL R1 in reset: actual %b%b%b expected 100", field_en, busy, done);
    end
    rst_n <= 1'b1;
    repeat (4) @(negedge clk);

    run_seq("R2 R8", 64'h0, 0, 1);        // R7 also: no bits
    run_seq("R3", 64'h0, 3, 1);
    run_seq("R4", {DW{1'b1}}, 3, 1);
    run_seq("R5 R6", {8'hA5, 56'h0}, 8, 1);
    run_seq("R7", 64'hF0F0_1234_8000_0001, 100, 1);
    run_seq("R10", {8'h6C, 56'h0}, 6, 3);

    // R9: start pulses throughout a running sequence
    tag = "R9"; tick_div = 2;
    pulse_start({4'b1001, 60'h0}, 4);
    while (busy === 1'b1) begin
      data <= ~data; nbits <= 7'd50; start <= 1'b1;
      @(negedge clk);
      start <= 1'b0;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);

    // R11: start exactly in the done cycle
    tag = "R11"; tick_div = 1;
    pulse_start({2'b10, 62'h0}, 2);
    wait_done();
    data <= {2'b01, 62'h0}; nbits <= 7'd2; start <= 1'b1;
    @(negedge clk);
    start <= 1'b0;
    checks++;
    if (busy !== 1'b1) begin
      fails++;
      $display("FAIL R11 busy after start in done cycle: actual %b expected 1", busy);
    end
    wait_done();
    repeat (3) @(negedge clk);

    tag = "R1";
    checks++;
    if (field_en !== 1'b1 || busy !== 1'b0) begin
      fails++;
      $display("FAIL R1 idle state: actual %b%b expected 10", field_en, busy);
    end
    finish_run();
  end
endmodule